// File: doc/BRIEF.md
# Memory Read Request Splitter

This block turns one large read command into a series of memory read request headers that a link may legally send. A command gives a start address and a byte count. The block cuts it into chunks. Each chunk is no larger than the configured maximum read request size, and no chunk runs past a 4 KiB address page. Chunks come out in address order on a valid/ready stream. Each chunk carries the header fields that a later serializer needs: format, type, address, length in doublewords and a transaction tag.

Reads are non-posted, so every chunk claims a tag from an internal pool before it is offered. A tag stays claimed until the completion side hands it back on the tag return port. When every tag is in use, the header stream waits. The block accepts a new command only after the last header of the current one has been taken.

Top module: `memrd_splitter`

## Requirements
- R1: After reset, and after a reset applied in the middle of a command, `req_valid` is 0 and `cmd_ready` is 1.
- R2: Each chunk is the smallest of three values: the bytes still owed, the maximum size, and the bytes up to the next 4096-byte page. The maximum size is 128 << `cmd_max_code` bytes for codes 0 to 5, and 4096 bytes for codes 6 and 7. The code is sampled when the command is accepted.
- R3: No emitted request spans a 4096-byte page: address[11:0] plus the chunk bytes is at most 4096.
- R4: Chunks are contiguous. Each one starts where the previous one ended, and together they cover the whole command. `req_last` is 1 only on the final chunk. `cmd_ready` returns to 1 in the cycle after the final header is taken.
- R5: `req_fmt` is 3'b000 when address bits [63:32] are all zero and 3'b001 otherwise, and this is chosen for each chunk. `req_type` is always 5'b00000.
- R6: `req_len_dw` holds chunk bytes / 4 in 10 bits, so a 1024-DW chunk is encoded as 0.
- R7: While `req_valid` is 1 and `req_ready` is 0, every header output keeps its value and `req_valid` stays 1.
- R8: Each header carries the lowest-numbered tag that is not outstanding. A tag stays outstanding until it is returned through `tag_ret_valid`/`tag_ret_id`. A return and a new claim in the same cycle both take effect.
- R9: When no tag is free, `req_valid` stays 0. A returned tag is used for the next header, which appears two cycles after the return edge.
- R10: `cmd_ready` is 0 while a command is in progress or a header is pending. A command whose byte count is below 4 produces no header and leaves the block ready.
- R11: Address bits [1:0] and byte-count bits [1:0] of a command are ignored and treated as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Byte count |
| cmd_max_code | input | 3 | Maximum request size code |
| req_valid | output | 1 | Header offered |
| req_ready | input | 1 | Header taken when high together with req_valid |
| req_fmt | output | 3 | Header format, 32-bit or 64-bit address form |
| req_type | output | 5 | Header type, memory read |
| req_addr | output | ADDR_W | Chunk start address |
| req_len_dw | output | 10 | Chunk length in doublewords, 0 means 1024 |
| req_tag | output | TAG_W | Tag claimed by the chunk |
| req_last | output | 1 | Final chunk of the command |
| tag_ret_valid | input | 1 | A tag is handed back |
| tag_ret_id | input | TAG_W | Tag being handed back |

## Verification
Two things can happen in the same cycle: the tag pool frees a returned tag and also claims a tag for the next chunk. The table-driven part of the bench returns each tag in the cycle after the header that used it is taken. During long commands, the next chunk's claim therefore lands on the same edge as that return. Expected tags are judged by tracking which tags are outstanding, and the directed stall test checks the lowest-free order and the two-cycle delay after a tag comes back.

// File: rtl/mrd_split_pkg.sv
package mrd_split_pkg;

    localparam int unsigned PAGE_BYTES = 4096;
    localparam int unsigned CHUNK_W    = 13;   // holds 0..4096
    localparam int unsigned LENF_W     = 10;   // header length field width
    localparam int unsigned CODE_W     = 3;

    localparam logic [2:0] FMT_RD_A32 = 3'b000;
    localparam logic [2:0] FMT_RD_A64 = 3'b001;
    localparam logic [4:0] TYPE_MRD   = 5'b00000;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } split_st_e;

    // Largest chunk allowed by the size code; codes above 5 clamp to one page.
    function automatic logic [CHUNK_W-1:0] max_req_bytes(input logic [CODE_W-1:0] code);
        if (code > 3'd5) begin
            return CHUNK_W'(PAGE_BYTES);
        end
        return CHUNK_W'(128) << code;
    endfunction

endpackage

// File: rtl/mrd_chunk_calc.sv
module mrd_chunk_calc
    import mrd_split_pkg::*;
#(
    parameter int unsigned LEN_W = 32
) (
    input  logic [11:0]         page_off,
    input  logic [LEN_W-1:0]    rem_bytes,
    input  logic [CODE_W-1:0]   size_code,
    output logic [CHUNK_W-1:0]  chunk_bytes,
    output logic [LENF_W-1:0]   len_field
);

    logic [CHUNK_W-1:0] cap_bytes;
    logic [CHUNK_W-1:0] to_page;
    logic [CHUNK_W-1:0] lim_bytes;

    always_comb begin
        cap_bytes = max_req_bytes(size_code);
        to_page   = CHUNK_W'(PAGE_BYTES) - {1'b0, page_off};
        lim_bytes = (cap_bytes < to_page) ? cap_bytes : to_page;
        if (rem_bytes < LEN_W'(lim_bytes)) begin
            chunk_bytes = rem_bytes[CHUNK_W-1:0];
        end else begin
            chunk_bytes = lim_bytes;
        end
        // 4096 bytes -> 1024 DW, whose 10-bit encoding wraps to zero
        len_field = chunk_bytes[LENF_W+1:2];
    end

endmodule

// File: rtl/mrd_tag_pool.sv
module mrd_tag_pool #(
    parameter int unsigned TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic             rel_en,
    input  logic [TAG_W-1:0] rel_id,
    output logic             avail,
    output logic [TAG_W-1:0] alloc_id
);

    localparam int unsigned NUM_TAGS = 1 << TAG_W;

    typedef struct packed {
        logic [NUM_TAGS-1:0] busy;
    } pool_t;

    pool_t pool_d, pool_q;

    // lowest free index wins
    always_comb begin
        alloc_id = '0;
        avail    = 1'b0;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            if (!pool_q.busy[i]) begin
                alloc_id = TAG_W'(i);
                avail    = 1'b1;
            end
        end
    end

    always_comb begin
        pool_d = pool_q;
        if (rel_en) begin
            pool_d.busy[rel_id] = 1'b0;
        end
        if (alloc_en) begin
            pool_d.busy[alloc_id] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pool_q <= '0;
        end else begin
            pool_q <= pool_d;
        end
    end

    AST_CLAIM_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> avail);                                            // R9
    AST_CLAIM_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> pool_q.busy[$past(alloc_id)]);                     // R8

endmodule

// File: rtl/memrd_splitter.sv
module memrd_splitter
    import mrd_split_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned LEN_W  = 32,
    parameter int unsigned TAG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [2:0]        cmd_max_code,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [2:0]        req_fmt,
    output logic [4:0]        req_type,
    output logic [ADDR_W-1:0] req_addr,
    output logic [9:0]        req_len_dw,
    output logic [TAG_W-1:0]  req_tag,
    output logic              req_last,
    input  logic              tag_ret_valid,
    input  logic [TAG_W-1:0]  tag_ret_id
);

    localparam logic [ADDR_W-1:0] ADDR_DW_MASK = ~ADDR_W'(3);
    localparam logic [LEN_W-1:0]  LEN_DW_MASK  = ~LEN_W'(3);

    typedef struct packed {
        split_st_e           st;
        logic [ADDR_W-1:0]   addr;
        logic [LEN_W-1:0]    rem;
        logic [CODE_W-1:0]   code;
        logic                o_vld;
        logic [2:0]          o_fmt;
        logic [ADDR_W-1:0]   o_addr;
        logic [LENF_W-1:0]   o_len;
        logic [TAG_W-1:0]    o_tag;
        logic                o_last;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic               take;
    logic               tag_avail;
    logic [TAG_W-1:0]   tag_next;
    logic [CHUNK_W-1:0] chunk_bytes;
    logic [LENF_W-1:0]  chunk_lenf;
    logic               hi_nz;
    logic [LEN_W-1:0]   cmd_len_al;

    mrd_chunk_calc #(
        .LEN_W (LEN_W)
    ) i_chunk_calc (
        .page_off    (ctl_q.addr[11:0]),
        .rem_bytes   (ctl_q.rem),
        .size_code   (ctl_q.code),
        .chunk_bytes (chunk_bytes),
        .len_field   (chunk_lenf)
    );

    mrd_tag_pool #(
        .TAG_W (TAG_W)
    ) i_tag_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_en (take),
        .rel_en   (tag_ret_valid),
        .rel_id   (tag_ret_id),
        .avail    (tag_avail),
        .alloc_id (tag_next)
    );

    generate
        if (ADDR_W > 32) begin : g_wide_addr
            assign hi_nz = |ctl_q.addr[ADDR_W-1:32];

            AST_FMT_FOLLOWS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
                req_valid |-> ((req_fmt == FMT_RD_A64) == (|req_addr[ADDR_W-1:32])));  // R5
        end else begin : g_narrow_addr
            assign hi_nz = 1'b0;
        end
    endgenerate

    assign cmd_ready  = (ctl_q.st == ST_IDLE) && !ctl_q.o_vld;
    assign cmd_len_al = cmd_len & LEN_DW_MASK;
    assign take       = (ctl_q.st == ST_RUN) && (!ctl_q.o_vld || req_ready) && tag_avail;

    always_comb begin
        ctl_d = ctl_q;

        if (ctl_q.o_vld && req_ready) begin
            ctl_d.o_vld = 1'b0;
        end

        if (cmd_valid && cmd_ready) begin
            ctl_d.addr = cmd_addr & ADDR_DW_MASK;
            ctl_d.rem  = cmd_len_al;
            ctl_d.code = cmd_max_code;
            if (cmd_len_al != '0) begin
                ctl_d.st = ST_RUN;
            end
        end

        if (take) begin
            ctl_d.o_vld  = 1'b1;
            ctl_d.o_fmt  = hi_nz ? FMT_RD_A64 : FMT_RD_A32;
            ctl_d.o_addr = ctl_q.addr;
            ctl_d.o_len  = chunk_lenf;
            ctl_d.o_tag  = tag_next;
            ctl_d.o_last = (ctl_q.rem == LEN_W'(chunk_bytes));
            ctl_d.addr   = ctl_q.addr + ADDR_W'(chunk_bytes);
            ctl_d.rem    = ctl_q.rem - LEN_W'(chunk_bytes);
            if (ctl_q.rem == LEN_W'(chunk_bytes)) begin
                ctl_d.st = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_valid  = ctl_q.o_vld;
    assign req_fmt    = ctl_q.o_fmt;
    assign req_type   = TYPE_MRD;
    assign req_addr   = ctl_q.o_addr;
    assign req_len_dw = ctl_q.o_len;
    assign req_tag    = ctl_q.o_tag;
    assign req_last   = ctl_q.o_last;

    logic [CHUNK_W:0] hdr_end;
    assign hdr_end = {2'b00, req_addr[11:0]}
                   + ((req_len_dw == '0) ? (CHUNK_W+1)'(PAGE_BYTES)
                                         : {{(CHUNK_W-LENF_W-1){1'b0}}, req_len_dw, 2'b00});

    AST_PAGE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (hdr_end <= (CHUNK_W+1)'(PAGE_BYTES)));                  // R3
    AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len_dw)
                                       && $stable(req_tag) && $stable(req_fmt) && $stable(req_last))); // R7
    AST_EMPTY_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_len_al == '0)) |=> (!req_valid && cmd_ready));  // R10

endmodule

// File: tb/test_memrd_splitter.sv
module test_memrd_splitter;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 2;
    localparam int NV = 7;

    localparam logic [63:0] V_ADDR [NV] = '{64'h0, 64'h0, 64'hF80, 64'hFFFF_F800,
                                            64'h1_2345_6000, 64'h10, 64'h7FC};
    localparam logic [31:0] V_LEN  [NV] = '{32'd4096, 32'd512, 32'd1024, 32'd4096,
                                            32'd8192, 32'd4, 32'd3000};
    localparam logic [2:0]  V_CODE [NV] = '{3'd5, 3'd0, 3'd2, 3'd5, 3'd7, 3'd1, 3'd3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [63:0] cmd_addr = '0;
    logic [31:0] cmd_len = '0;
    logic [2:0] cmd_max_code = '0;
    logic req_valid;
    logic req_ready = 1'b0;
    logic [2:0] req_fmt;
    logic [4:0] req_type;
    logic [63:0] req_addr;
    logic [9:0] req_len_dw;
    logic [TW-1:0] req_tag;
    logic req_last;
    logic tag_ret_valid = 1'b0;
    logic [TW-1:0] tag_ret_id = '0;

    int checks = 0;
    int fails = 0;
    logic [(1<<TW)-1:0] outstanding = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memrd_splitter #(.ADDR_W(64), .LEN_W(32), .TAG_W(TW)) i_memrd_splitter (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_max_code(cmd_max_code),
        .req_valid(req_valid), .req_ready(req_ready), .req_fmt(req_fmt),
        .req_type(req_type), .req_addr(req_addr), .req_len_dw(req_len_dw),
        .req_tag(req_tag), .req_last(req_last),
        .tag_ret_valid(tag_ret_valid), .tag_ret_id(tag_ret_id));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic longint unsigned exp_chunk(input longint unsigned a,
                                                  input longint unsigned rem,
                                                  input int unsigned code);
        longint unsigned mx, pg, r;
        mx = (code > 5) ? 4096 : (longint'(128) << code);
        pg = 4096 - (a % 4096);
        r = rem;
        if (mx < r) r = mx;
        if (pg < r) r = pg;
        return r;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        tag_ret_valid = 1'b0;
        outstanding = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Issue one command and drain it, returning each tag one cycle after use.
    task automatic run_cmd(input logic [63:0] a, input logic [31:0] l,
                           input logic [2:0] c, output int n_hdr);
        longint unsigned ea, er, n;
        bit done;
        bit have_prev;
        logic [TW-1:0] prev;
        int guard;
        ea = {a[63:2], 2'b00};
        er = {l[31:2], 2'b00};
        done = 0; have_prev = 0; prev = '0; guard = 0; n_hdr = 0;
        req_ready = 1'b1;
        chk(cmd_ready === 1'b1, "R10", "ready before command", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_addr = a; cmd_len = l; cmd_max_code = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && guard < 200) begin
            guard++;
            tag_ret_valid = 1'b0;
            if (req_valid) begin
                n = exp_chunk(ea, er, c);
                n_hdr++;
                chk(req_addr == ea, "R4", "chunk address", req_addr, ea);
                chk(longint'(req_len_dw) == ((n / 4) % 1024), "R2", "chunk length field (R6)",
                    req_len_dw, (n / 4) % 1024);
                chk(req_fmt == (((ea >> 32) != 0) ? 3'b001 : 3'b000), "R5", "format",
                    req_fmt, ((ea >> 32) != 0) ? 1 : 0);
                chk(req_type == 5'b00000, "R5", "type", req_type, 0);
                chk(req_last == (er == n), "R4", "last flag", req_last, (er == n));
                chk(outstanding[req_tag] == 1'b0, "R8", "tag already outstanding", req_tag, -1);
                outstanding[req_tag] = 1'b1;
                if (have_prev) begin
                    tag_ret_valid = 1'b1;
                    tag_ret_id = prev;
                    outstanding[prev] = 1'b0;
                end
                prev = req_tag;
                have_prev = 1;
                ea += n;
                er -= n;
                if (er == 0) done = 1;
            end
            @(negedge clk);
        end
        chk(done, "R4", "command fully covered", er, 0);
        tag_ret_valid = 1'b1;
        tag_ret_id = prev;
        outstanding[prev] = 1'b0;
        @(negedge clk);
        tag_ret_valid = 1'b0;
        chk(cmd_ready == 1'b1 && req_valid == 1'b0, "R4", "idle after final chunk",
            {cmd_ready, req_valid}, 2'b10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int nh;
        logic [TW-1:0] seen [8];
        logic [63:0] seen_addr [8];
        int cnt;
        logic [63:0] h_addr;
        logic [9:0] h_len;
        logic [TW-1:0] h_tag;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_valid == 1'b0, "R1", "req_valid after reset", req_valid, 0);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);

        // table of commands: R2 R3 R4 R5 R6 R8 checked per chunk
        for (int v = 0; v < NV; v++) begin
            run_cmd(V_ADDR[v], V_LEN[v], V_CODE[v], nh);
        end

        // R11: low bits of address and length ignored
        run_cmd(64'h1003, 32'h103, 3'd5, nh);
        chk(nh == 1, "R11", "one chunk from unaligned command", nh, 1);

        // R10: command shorter than one DW produces no header
        req_ready = 1'b1;
        cmd_valid = 1'b1; cmd_addr = 64'h40; cmd_len = 32'd3; cmd_max_code = 3'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        cnt = 0;
        for (int k = 0; k < 4; k++) begin
            if (req_valid) cnt++;
            @(negedge clk);
        end
        chk(cnt == 0, "R10", "headers from empty command", cnt, 0);
        chk(cmd_ready == 1'b1, "R10", "ready after empty command", cmd_ready, 1);

        // R7: back-pressure holds header
        req_ready = 1'b0;
        cmd_valid = 1'b1; cmd_addr = 64'h0; cmd_len = 32'd512; cmd_max_code = 3'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        h_addr = req_addr; h_len = req_len_dw; h_tag = req_tag;
        chk(req_valid == 1'b1, "R7", "valid under back-pressure", req_valid, 1);
        repeat (3) @(negedge clk);
        chk(req_valid == 1'b1 && req_addr == h_addr && req_len_dw == h_len && req_tag == h_tag,
            "R7", "header stable", req_addr, h_addr);
        chk(cmd_ready == 1'b0, "R10", "busy blocks command", cmd_ready, 0);
        do_reset();
        // R1: reset mid-command
        chk(req_valid == 1'b0 && cmd_ready == 1'b1, "R1", "state after mid-command reset",
            {req_valid, cmd_ready}, 2'b01);

        // R9 / R8: tag exhaustion with four tags, no returns
        req_ready = 1'b1;
        cmd_valid = 1'b1; cmd_addr = 64'h0; cmd_len = 32'd1024; cmd_max_code = 3'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        cnt = 0;
        for (int k = 0; k < 10; k++) begin
            if (req_valid && cnt < 8) begin
                seen[cnt] = req_tag;
                seen_addr[cnt] = req_addr;
                cnt++;
            end
            @(negedge clk);
        end
        chk(cnt == 4, "R9", "headers before tags run out", cnt, 4);
        for (int k = 0; k < 4; k++) begin
            chk(seen[k] == TW'(k), "R8", "lowest-free tag order", seen[k], k);
            chk(seen_addr[k] == 64'(k * 128), "R2", "128-byte chunk address", seen_addr[k], k * 128);
        end
        chk(req_valid == 1'b0, "R9", "stalled without tags", req_valid, 0);
        tag_ret_valid = 1'b1; tag_ret_id = 2'd2;
        @(negedge clk);
        tag_ret_valid = 1'b0;
        chk(req_valid == 1'b0, "R9", "one cycle after return", req_valid, 0);
        @(negedge clk);
        chk(req_valid == 1'b1, "R9", "header after return", req_valid, 1);
        chk(req_tag == 2'd2, "R8", "returned tag reused", req_tag, 2);
        chk(req_addr == 64'h200, "R4", "fifth chunk address", req_addr, 64'h200);
        do_reset();
        chk(req_valid == 1'b0 && cmd_ready == 1'b1, "R1", "state after final reset",
            {req_valid, cmd_ready}, 2'b01);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule